// File: doc/BRIEF.md
# Received Frame Length Counter with End-Count Queue

This block measures the length of received synchronous frames. A down-counter is loaded with a programmed start value when a frame begins. It then steps down by one for every character that the receiver delivers. When the frame ends, the value left in the counter is written into a small first-in first-out queue. Software reads the queue afterwards and subtracts each entry from the start value to find that frame's character count.

If a frame carries more characters than the start value allows, the counter stops at zero and does not wrap. The block then raises a sticky overlong flag, and that flag drives an interrupt line while the interrupt is enabled. The queue is four entries deep by default. A frame end that arrives while the queue is full loses its value and sets a sticky overflow flag. A read and a write in the same cycle are both accepted.

The external reset is asynchronous and active-low. It is released to the logic through a two-stage synchronizer, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `frame_len_tracker`

## Requirements
- R1: While reset is applied and until the first stimulus afterwards, `fifo_level_o` is 0 and `head_valid_o`, `fifo_full_o`, `overlong_o`, `queue_ovf_o` and `irq_o` are all 0.
- R2: A cycle with `frame_start_i` high loads `preload_i` into the counter.
- R3: Each cycle with `char_i` high lowers the counter by exactly one when the counter is above zero.
- R4: A character strobe that finds the counter at 0 leaves it at 0 and sets `overlong_o`. That flag stays set until the next frame start clears it.
- R5: `irq_o` is high exactly when `irq_en_i` is high and `overlong_o` is set.
- R6: A cycle with `frame_end_i` high pushes the counter value after that cycle's load and decrement are applied. Entries leave in arrival order. `head_o` shows the oldest entry and reads 0 while the queue is empty, and `head_valid_o` is high when `fifo_level_o` is above 0.
- R7: The queue holds at most DEPTH (4) entries, and `fifo_full_o` is high when it holds DEPTH entries. A frame end while the queue is full, with no pop in the same cycle, drops the value and sets `queue_ovf_o`, which then stays set until reset.
- R8: A pop and a frame end in the same cycle are both honoured even when the queue is full, and the level stays unchanged.
- R9: A pop while the queue is empty has no effect.
- R10: When `frame_start_i` and `char_i` are high in the same cycle, the load happens first and the character is then counted against the new value. With a preload of 0, this sets `overlong_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| preload_i | input | 16 | Start value loaded at frame start |
| frame_start_i | input | 1 | Frame start strobe |
| char_i | input | 1 | Received character strobe |
| frame_end_i | input | 1 | Frame end strobe, pushes the count |
| pop_i | input | 1 | Removes the oldest queue entry |
| irq_en_i | input | 1 | Interrupt enable for the overlong flag |
| head_o | output | 16 | Oldest queued end count, 0 when empty |
| head_valid_o | output | 1 | Queue not empty |
| fifo_full_o | output | 1 | Queue holds DEPTH entries |
| fifo_level_o | output | 3 | Number of queued entries |
| overlong_o | output | 1 | Sticky overlong flag |
| queue_ovf_o | output | 1 | Sticky queue overflow flag |
| irq_o | output | 1 | Overlong interrupt |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is a frame end and a pop. The bench drives both together while the queue is full and while it is empty. The level is expected to stay the same when the queue is full. When the queue is empty, the pop is ignored and only the push takes effect. A frame end while the queue is full with no pop must raise the overflow flag.

The second pair is a frame start and a character strobe. The bench drives both together with a preload of 1 and with a preload of 0. The expected counts and overlong flags come from a reference model in the bench. That model also follows long random runs with small preload values, so that saturation and overflow occur often.

// File: rtl/flt_pkg.sv
package flt_pkg;
  localparam int unsigned FLT_CNT_W_DEF = 16;
  localparam int unsigned FLT_DEPTH_DEF = 4;

  function automatic int unsigned lvl_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/flt_counter.sv
module flt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] load_val,
  input  logic             start,
  input  logic             chr,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             overlong_q
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovl_d;
  logic             upd_en;

  always_comb begin
    cnt_nxt = cnt_q;
    ovl_d   = overlong_q;
    if (start) begin
      cnt_nxt = load_val;
      ovl_d   = 1'b0;
    end
    if (chr) begin
      if (cnt_nxt == '0) ovl_d = 1'b1;
      else               cnt_nxt = cnt_nxt - 1'b1;
    end
  end

  assign upd_en = start | chr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      overlong_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q      <= cnt_nxt;
      overlong_q <= ovl_d;
    end
  end
endmodule

// File: rtl/flt_fifo.sv
module flt_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     head,
  output logic             valid,
  output logic             full,
  output logic [LVL_W-1:0] level,
  output logic             ovf
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             ovf_q, ovf_d;
  logic             pop_ok, push_ok, st_en;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    pop_ok  = pop_req && (lvl_q != '0);
    push_ok = push_req && ((lvl_q != FULL_LVL) || pop_ok);
    wr_d    = push_ok ? bump(wr_q) : wr_q;
    rd_d    = pop_ok  ? bump(rd_q) : rd_q;
    lvl_d   = lvl_q + LVL_W'(push_ok) - LVL_W'(pop_ok);
    ovf_d   = ovf_q | (push_req & ~push_ok);
    st_en   = push_req | pop_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
      ovf_q <= 1'b0;
    end else if (st_en) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end

  assign valid = (lvl_q != '0);
  assign full  = (lvl_q == FULL_LVL);
  assign level = lvl_q;
  assign ovf   = ovf_q;
  assign head  = valid ? mem[rd_q] : '0;
endmodule

// File: rtl/frame_len_tracker.sv
module frame_len_tracker
  import flt_pkg::*;
#(
  parameter int unsigned CNT_W = FLT_CNT_W_DEF,
  parameter int unsigned DEPTH = FLT_DEPTH_DEF,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] preload_i,
  input  logic             frame_start_i,
  input  logic             char_i,
  input  logic             frame_end_i,
  input  logic             pop_i,
  input  logic             irq_en_i,
  output logic [CNT_W-1:0] head_o,
  output logic             head_valid_o,
  output logic             fifo_full_o,
  output logic [LVL_W-1:0] fifo_level_o,
  output logic             overlong_o,
  output logic             queue_ovf_o,
  output logic             irq_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [CNT_W-1:0] cnt_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  flt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_val  (preload_i),
    .start     (frame_start_i),
    .chr       (char_i),
    .cnt_nxt   (cnt_nxt),
    .overlong_q(overlong_o)
  );

  flt_fifo #(.W(CNT_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .push_req(frame_end_i),
    .pop_req (pop_i),
    .din     (cnt_nxt),
    .head    (head_o),
    .valid   (head_valid_o),
    .full    (fifo_full_o),
    .level   (fifo_level_o),
    .ovf     (queue_ovf_o)
  );

  assign irq_o = irq_en_i & overlong_o;
endmodule

// File: rtl/flt_checker.sv
module flt_checker #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             char_i,
  input logic             frame_start_i,
  input logic             frame_end_i,
  input logic             pop_i,
  input logic             irq_en_i,
  input logic [CNT_W-1:0] head_o,
  input logic             head_valid_o,
  input logic             fifo_full_o,
  input logic [LVL_W-1:0] fifo_level_o,
  input logic             overlong_o,
  input logic             queue_ovf_o,
  input logic             irq_o
);
  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level_o <= LVL_W'(DEPTH));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    queue_ovf_o |=> queue_ovf_o);

  assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(queue_ovf_o) |-> $past(frame_end_i && fifo_full_o && !pop_i));

  assert_overlong_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overlong_o) |-> $past(char_i));

  assert_overlong_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    overlong_o && !frame_start_i |=> overlong_o);

  assert_same_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_i && pop_i && head_valid_o |=> $stable(fifo_level_o));

  assert_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && !frame_end_i && !head_valid_o |=> fifo_level_o == '0);

  assert_empty_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !head_valid_o |-> head_o == '0);

  assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_en_i);
endmodule

bind frame_len_tracker flt_checker #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .char_i       (char_i),
  .frame_start_i(frame_start_i),
  .frame_end_i  (frame_end_i),
  .pop_i        (pop_i),
  .irq_en_i     (irq_en_i),
  .head_o       (head_o),
  .head_valid_o (head_valid_o),
  .fifo_full_o  (fifo_full_o),
  .fifo_level_o (fifo_level_o),
  .overlong_o   (overlong_o),
  .queue_ovf_o  (queue_ovf_o),
  .irq_o        (irq_o)
);

// File: tb/frame_len_tracker_tb.sv
`timescale 1ns/1ps
module frame_len_tracker_tb;
  localparam int CW = 16;
  localparam int DP = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] preload_i;
  logic          frame_start_i, char_i, frame_end_i, pop_i, irq_en_i;
  logic [CW-1:0] head_o;
  logic          head_valid_o, fifo_full_o, overlong_o, queue_ovf_o, irq_o;
  logic [2:0]    fifo_level_o;

  int checks = 0;
  int fails  = 0;

  int          m_cnt;
  bit          m_tl;
  bit          m_ovf;
  int          m_q[$];

  always #2.5 clk = ~clk;

  frame_len_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .preload_i(preload_i),
    .frame_start_i(frame_start_i), .char_i(char_i), .frame_end_i(frame_end_i),
    .pop_i(pop_i), .irq_en_i(irq_en_i), .head_o(head_o),
    .head_valid_o(head_valid_o), .fifo_full_o(fifo_full_o),
    .fifo_level_o(fifo_level_o), .overlong_o(overlong_o),
    .queue_ovf_o(queue_ovf_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_head();
    return (m_q.size() > 0) ? m_q[0] : 0;
  endfunction

  task automatic check_all();
    chk("R6 head", int'(head_o), exp_head());
    chk("R6 valid", int'(head_valid_o), int'(m_q.size() > 0));
    chk("R7 level", int'(fifo_level_o), m_q.size());
    chk("R7 full", int'(fifo_full_o), int'(m_q.size() == DP));
    chk("R4 overlong", int'(overlong_o), int'(m_tl));
    chk("R7 ovf", int'(queue_ovf_o), int'(m_ovf));
    chk("R5 irq", int'(irq_o), int'(irq_en_i && m_tl));
  endtask

  task automatic model(input bit s, input bit c, input bit e, input bit p, input int pre);
    bit do_pop, do_push;
    if (s) begin m_cnt = pre; m_tl = 1'b0; end
    if (c) begin
      if (m_cnt == 0) m_tl = 1'b1;
      else m_cnt = m_cnt - 1;
    end
    do_pop  = p && (m_q.size() > 0);
    do_push = e && ((m_q.size() < DP) || do_pop);
    if (e && !do_push) m_ovf = 1'b1;
    if (do_pop) void'(m_q.pop_front());
    if (do_push) m_q.push_back(m_cnt);
  endtask

  task automatic step(input bit s, input bit c, input bit e, input bit p, input int pre);
    frame_start_i = s; char_i = c; frame_end_i = e; pop_i = p;
    preload_i = CW'(pre);
    model(s, c, e, p, pre);
    @(posedge clk);
    #1;
    check_all();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    preload_i = '0; frame_start_i = 0; char_i = 0; frame_end_i = 0; pop_i = 0; irq_en_i = 0;
    m_cnt = 0; m_tl = 0; m_ovf = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 level", int'(fifo_level_o), 0);
    chk("R1 valid", int'(head_valid_o), 0);
    chk("R1 flags", int'({overlong_o, queue_ovf_o, irq_o, fifo_full_o}), 0);
    rst_n = 1'b1;
    repeat (3) step(0, 0, 0, 0, 0);
    chk("R1 after release", int'({head_valid_o, overlong_o, queue_ovf_o}), 0);

    // R2, R3: load 5, three characters, frame end -> 2
    step(1, 0, 0, 0, 5);
    repeat (3) step(0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R2 R3 end count", int'(head_o), 2);
    // R9: pop, then pop on empty
    step(0, 0, 0, 1, 0);
    chk("R6 empty head", int'(head_o), 0);
    step(0, 0, 0, 1, 0);
    chk("R9 empty pop level", int'(fifo_level_o), 0);

    // R10, R4, R5: start plus character with preload 1
    step(1, 1, 0, 0, 1);
    chk("R10 no overlong yet", int'(overlong_o), 0);
    step(0, 1, 0, 0, 0);
    chk("R4 overlong set", int'(overlong_o), 1);
    irq_en_i = 1'b1;
    #1 chk("R5 irq enabled", int'(irq_o), 1);
    step(0, 1, 1, 0, 0);
    chk("R4 saturated count", int'(head_o), 0);
    step(0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 9);
    chk("R4 cleared by start", int'(overlong_o), 0);
    step(1, 1, 0, 0, 0);
    chk("R10 preload zero", int'(overlong_o), 1);
    irq_en_i = 1'b0;

    // R7: fill and overflow
    step(1, 0, 0, 0, 7);
    repeat (4) step(0, 0, 1, 0, 0);
    chk("R7 full", int'(fifo_full_o), 1);
    chk("R7 no ovf yet", int'(queue_ovf_o), 0);
    step(0, 1, 1, 0, 0);
    chk("R7 ovf set", int'(queue_ovf_o), 1);
    chk("R7 level capped", int'(fifo_level_o), 4);
    // R8: pop with push while full
    step(0, 1, 1, 1, 0);
    chk("R8 level held", int'(fifo_level_o), 4);
    chk("R8 head advanced", int'(head_o), 7);
    repeat (4) step(0, 0, 0, 1, 0);
    chk("R8 last entry", int'(fifo_level_o), 0);
    // R9 variant: pop and push on empty
    step(0, 0, 1, 1, 0);
    chk("R9 push on empty with pop", int'(fifo_level_o), 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit s, c, e, p;
      s = ($urandom % 10) == 0;
      c = ($urandom % 2) == 0;
      e = ($urandom % 7) == 0;
      p = ($urandom % 4) == 0;
      if (($urandom % 16) == 0) irq_en_i = ~irq_en_i;
      step(s, c, e, p, int'($urandom % 12));
    end

    summary();
    $finish;
  end
endmodule